// File: doc/BRIEF.md
# Skeleton Token Matcher

This block turns a byte stream of a markup document into a stream of token IDs and raw bytes. Before a document arrives, a small content-addressable table is loaded with the strings of a tokenized document skeleton. Each entry holds a pattern of up to four bytes, a per-byte compare mask, the token ID to emit, and an ordering rule. Document data arrives as 32-bit words. Each word is split over four byte-lane FIFOs. The lanes are read back in stream order, so the matcher always looks at a window of the next four bytes.

When the window starts with a string stored in the table, the block emits that entry's token ID and consumes the matched bytes. When no entry hits, for example on attribute names or attribute values that the skeleton leaves out, the block emits the first byte unchanged and consumes only that byte. At most one item leaves per cycle, over a valid/ready handshake, so up to four bytes are absorbed per cycle.

The block also enforces token order. An entry can demand that the next token be one specific ID, and a broken demand latches an error flag. Entries marked free are accepted after any token and leave such a demand pending. A typical free entry is a closing bracket followed by whitespace.

Top module: `skelTokenMatcher`

## Requirements
- R1: After reset, inReady, outValid and parseErr are 0, and every table entry has an all-zero mask.
- R2: A cycle with ldValid high writes entry ldIndex and disarms the block. A ldDone pulse with ldValid low arms it. While disarmed, inReady and outValid stay 0.
- R3: Bits 7:0 of an accepted word are the first byte of the stream and bits 31:24 are the last. Each of the four lane FIFOs holds FIFO_DEPTH bytes. inReady is 0 while any lane is full.
- R4: The length of an entry is the index of the highest set bit of its mask, plus one. An entry hits when every window byte k with mask bit k set equals pattern bits 8k+7:8k. Bytes inside that length whose mask bit is clear are don't-care. On a hit the block outputs outIsToken=1 and outData equal to the token ID, and consumes that many bytes.
- R5: When no entry hits, the block outputs outIsToken=0 and outData equal to the first window byte, and consumes one byte.
- R6: When several entries hit, the entry with the lowest index wins.
- R7: A decision waits until four bytes are buffered. Once a word with inLast has been accepted, the remaining shorter tail is also matched, and an entry longer than the tail cannot hit.
- R8: An entry with ldFollowEn set makes a demand on the next non-free item: it must be a token with ID ldFollow. Any other item sets parseErr when it is handed over.
- R9: A token from an entry with ldFree set is never checked against a pending demand, and it leaves the demand unchanged.
- R10: parseErr stays set until a docStart pulse. docStart clears parseErr and the pending demand, empties the lane FIFOs and ends tail mode.
- R11: While outValid is 1 and outReady is 0, outValid and outData hold unless docStart, ldValid or an accepted word intervenes.
- R12: An entry whose mask is all zero never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Write one table entry |
| ldIndex | input | IDX_W | Entry index |
| ldPattern | input | 32 | Pattern bytes, bits 7:0 first |
| ldMask | input | 4 | Per-byte compare mask |
| ldToken | input | 8 | Token ID for the entry |
| ldFollow | input | 8 | Token ID demanded next |
| ldFollowEn | input | 1 | Enable the demand |
| ldFree | input | 1 | Token accepted in any order |
| ldDone | input | 1 | Table complete, arm matching |
| docStart | input | 1 | Start of a new document |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted |
| inData | input | 32 | Document word |
| inLast | input | 1 | Final word of the document |
| outValid | output | 1 | Output item valid |
| outReady | input | 1 | Consumer takes the item |
| outIsToken | output | 1 | 1 for a token ID, 0 for a raw byte |
| outData | output | 8 | Token ID or raw byte |
| parseErr | output | 1 | Latched order violation |

## Verification
The assertions check four things on every cycle: that loading disarms the input and output, that a stalled output holds, that the error flag only rises on a handover, and that the error flag only falls on docStart. The content of the item stream can only be shown by the bench scenarios. That covers which entry wins, how many bytes a match consumes, the wildcard bytes, the tail handling and the error outcome of each token order. For these, the bench compares every item against a model of the requirements that it runs over chosen documents and swept character streams.

// File: rtl/skelTokenPkg.sv
package skelTokenPkg;
  localparam int LANES   = 4;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = LANES * BYTE_W;
  localparam int TOKEN_W = 8;
  localparam int LEN_W   = 3;

  typedef struct packed {
    logic             flush;
    logic             push;
    logic             pop;
    logic [LEN_W-1:0] popLen;
  } ctrlStrobe_t;

  function automatic logic [LEN_W-1:0] maskLen(input logic [LANES-1:0] m);
    logic [LEN_W-1:0] n;
    n = '0;
    for (int k = 0; k < LANES; k++) begin
      if (m[k]) n = LEN_W'(k + 1);
    end
    return n;
  endfunction
endpackage

// File: rtl/skelByteFifo.sv
module skelByteFifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head = mem[rdPtr];
  assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/skelLaneBuffer.sv
module skelLaneBuffer import skelTokenPkg::*; #(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int SUM_W = $clog2(LANES * FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] inData,
  output logic [WORD_W-1:0] window,
  output logic [LEN_W-1:0]  availCl,
  output logic              laneFull
);
  logic [BYTE_W-1:0] heads  [LANES];
  logic [CNT_W-1:0]  counts [LANES];
  logic [LANES-1:0]  fulls;
  logic [LANES-1:0]  popLane;
  logic [1:0]        rdLane;
  logic [SUM_W-1:0]  total;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] offset;
    assign offset     = 2'(j) - rdLane;
    assign popLane[j] = strobe.pop && ({1'b0, offset} < strobe.popLen);

    skelByteFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (strobe.flush),
      .push     (strobe.push),
      .pushData (inData[j*BYTE_W +: BYTE_W]),
      .pop      (popLane[j]),
      .head     (heads[j]),
      .count    (counts[j]),
      .full     (fulls[j])
    );
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [1:0] ln;
      ln = rdLane + 2'(k);
      window[k*BYTE_W +: BYTE_W] = heads[ln];
    end
  end

  always_comb begin
    total = '0;
    for (int j = 0; j < LANES; j++) total = total + SUM_W'(counts[j]);
  end

  assign availCl  = (total >= SUM_W'(LANES)) ? LEN_W'(LANES) : total[LEN_W-1:0];
  assign laneFull = |fulls;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) rdLane <= '0;
    else if (strobe.pop)       rdLane <= rdLane + strobe.popLen[1:0];
  end
endmodule

// File: rtl/skelTokenCam.sv
module skelTokenCam import skelTokenPkg::*; #(
  parameter int ENTRIES = 256,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic [IDX_W-1:0]   ldIndex,
  input  logic [WORD_W-1:0]  ldPattern,
  input  logic [LANES-1:0]   ldMask,
  input  logic [TOKEN_W-1:0] ldToken,
  input  logic [TOKEN_W-1:0] ldFollow,
  input  logic               ldFollowEn,
  input  logic               ldFree,
  input  logic [WORD_W-1:0]  window,
  input  logic [LEN_W-1:0]   availCl,
  output logic               hit,
  output logic [LEN_W-1:0]   hitLen,
  output logic [TOKEN_W-1:0] hitToken,
  output logic [TOKEN_W-1:0] hitFollow,
  output logic               hitFollowEn,
  output logic               hitFree
);
  logic [WORD_W-1:0]  pattern  [ENTRIES];
  logic [LANES-1:0]   mask     [ENTRIES];
  logic [TOKEN_W-1:0] token    [ENTRIES];
  logic [TOKEN_W-1:0] follow   [ENTRIES];
  logic               followEn [ENTRIES];
  logic               freeTok  [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) mask[e] <= '0;
    end else if (ldValid) begin
      mask[ldIndex] <= ldMask;
    end
  end

  always_ff @(posedge clk) begin
    if (ldValid) begin
      pattern[ldIndex]  <= ldPattern;
      token[ldIndex]    <= ldToken;
      follow[ldIndex]   <= ldFollow;
      followEn[ldIndex] <= ldFollowEn;
      freeTok[ldIndex]  <= ldFree;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [LANES-1:0] byteOk;
    logic [LEN_W-1:0] len;
    for (genvar k = 0; k < LANES; k++) begin : g_byte
      assign byteOk[k] = !mask[e][k] ||
        (window[k*BYTE_W +: BYTE_W] == pattern[e][k*BYTE_W +: BYTE_W]);
    end
    assign len       = maskLen(mask[e]);
    assign hitVec[e] = (len != '0) && (len <= availCl) && (&byteOk);
  end

  always_comb begin
    hit         = 1'b0;
    hitLen      = '0;
    hitToken    = '0;
    hitFollow   = '0;
    hitFollowEn = 1'b0;
    hitFree     = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hitVec[e]) begin
        hit         = 1'b1;
        hitLen      = maskLen(mask[e]);
        hitToken    = token[e];
        hitFollow   = follow[e];
        hitFollowEn = followEn[e];
        hitFree     = freeTok[e];
      end
    end
  end
endmodule

// File: rtl/skelMatchCtrl.sv
module skelMatchCtrl import skelTokenPkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic               ldDone,
  input  logic               docStart,
  input  logic               inValid,
  input  logic               inLast,
  input  logic               laneFull,
  input  logic               outReady,
  input  logic [LEN_W-1:0]   availCl,
  input  logic               hit,
  input  logic [LEN_W-1:0]   hitLen,
  input  logic [TOKEN_W-1:0] hitToken,
  input  logic [TOKEN_W-1:0] hitFollow,
  input  logic               hitFollowEn,
  input  logic               hitFree,
  input  logic [BYTE_W-1:0]  headByte,
  output logic               inReady,
  output logic               outValid,
  output logic               outIsToken,
  output logic [TOKEN_W-1:0] outData,
  output logic               parseErr,
  output ctrlStrobe_t        strobe
);
  logic               armed;
  logic               drain;
  logic               pending;
  logic [TOKEN_W-1:0] pendId;
  logic               windowReady;
  logic               handover;

  assign windowReady = (availCl == LEN_W'(LANES)) || (drain && availCl != '0);
  assign outValid    = armed && windowReady && !docStart;
  assign inReady     = armed && !laneFull && !docStart && !ldValid;
  assign outIsToken  = hit;
  assign outData     = hit ? hitToken : TOKEN_W'(headByte);
  assign handover    = outValid && outReady;

  always_comb begin
    strobe.flush  = docStart;
    strobe.push   = inValid && inReady;
    strobe.pop    = handover;
    strobe.popLen = hit ? hitLen : LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)       armed <= 1'b0;
    else if (ldValid) armed <= 1'b0;
    else if (ldDone)  armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || docStart) begin
      drain    <= 1'b0;
      pending  <= 1'b0;
      pendId   <= '0;
      parseErr <= 1'b0;
    end else begin
      if (inValid && inReady && inLast) drain <= 1'b1;
      if (handover && !(hit && hitFree)) begin
        if (pending && !(hit && hitToken == pendId)) parseErr <= 1'b1;
        pending <= hit && hitFollowEn;
        pendId  <= hitFollow;
      end
    end
  end
endmodule

// File: rtl/skelTokenMatcher.sv
module skelTokenMatcher import skelTokenPkg::*; #(
  parameter int ENTRIES    = 256,
  parameter int FIFO_DEPTH = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic [IDX_W-1:0]   ldIndex,
  input  logic [WORD_W-1:0]  ldPattern,
  input  logic [LANES-1:0]   ldMask,
  input  logic [TOKEN_W-1:0] ldToken,
  input  logic [TOKEN_W-1:0] ldFollow,
  input  logic               ldFollowEn,
  input  logic               ldFree,
  input  logic               ldDone,
  input  logic               docStart,
  input  logic               inValid,
  output logic               inReady,
  input  logic [WORD_W-1:0]  inData,
  input  logic               inLast,
  output logic               outValid,
  input  logic               outReady,
  output logic               outIsToken,
  output logic [TOKEN_W-1:0] outData,
  output logic               parseErr
);
  ctrlStrobe_t        strobe;
  logic [WORD_W-1:0]  window;
  logic [LEN_W-1:0]   availCl;
  logic               laneFull;
  logic               hit, hitFollowEn, hitFree;
  logic [LEN_W-1:0]   hitLen;
  logic [TOKEN_W-1:0] hitToken, hitFollow;

  skelLaneBuffer #(.FIFO_DEPTH(FIFO_DEPTH)) u_lanes (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .window   (window),
    .availCl  (availCl),
    .laneFull (laneFull)
  );

  skelTokenCam #(.ENTRIES(ENTRIES)) u_cam (
    .clk         (clk),
    .rstN        (rstN),
    .ldValid     (ldValid),
    .ldIndex     (ldIndex),
    .ldPattern   (ldPattern),
    .ldMask      (ldMask),
    .ldToken     (ldToken),
    .ldFollow    (ldFollow),
    .ldFollowEn  (ldFollowEn),
    .ldFree      (ldFree),
    .window      (window),
    .availCl     (availCl),
    .hit         (hit),
    .hitLen      (hitLen),
    .hitToken    (hitToken),
    .hitFollow   (hitFollow),
    .hitFollowEn (hitFollowEn),
    .hitFree     (hitFree)
  );

  skelMatchCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ldValid     (ldValid),
    .ldDone      (ldDone),
    .docStart    (docStart),
    .inValid     (inValid),
    .inLast      (inLast),
    .laneFull    (laneFull),
    .outReady    (outReady),
    .availCl     (availCl),
    .hit         (hit),
    .hitLen      (hitLen),
    .hitToken    (hitToken),
    .hitFollow   (hitFollow),
    .hitFollowEn (hitFollowEn),
    .hitFree     (hitFree),
    .headByte    (window[BYTE_W-1:0]),
    .inReady     (inReady),
    .outValid    (outValid),
    .outIsToken  (outIsToken),
    .outData     (outData),
    .parseErr    (parseErr),
    .strobe      (strobe)
  );
endmodule

// File: rtl/skelTokenMatcherChecker.sv
module skelTokenMatcherChecker (
  input logic       clk,
  input logic       rstN,
  input logic       ldValid,
  input logic       docStart,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic       outIsToken,
  input logic [7:0] outData,
  input logic       parseErr
);
  assert_load_disarms_R2: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |=> (!inReady && !outValid));

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !docStart && !ldValid && !(inValid && inReady))
      |=> (outValid && $stable(outData) && $stable(outIsToken)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (parseErr && !docStart) |=> parseErr);

  assert_err_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    docStart |=> !parseErr);

  assert_err_on_handover_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!parseErr && !(outValid && outReady)) |=> !parseErr);
endmodule

bind skelTokenMatcher skelTokenMatcherChecker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .ldValid    (ldValid),
  .docStart   (docStart),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outIsToken (outIsToken),
  .outData    (outData),
  .parseErr   (parseErr)
);

// File: tb/skelTokenMatcher_bench.sv
module skelTokenMatcher_bench;
  localparam int ENTRIES = 16;
  localparam int DEPTH   = 4;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0, ldFollowEn = 1'b0, ldFree = 1'b0, ldDone = 1'b0;
  logic [IDX_W-1:0] ldIndex = '0;
  logic [31:0] ldPattern = '0;
  logic [3:0]  ldMask = '0;
  logic [7:0]  ldToken = '0, ldFollow = '0;
  logic docStart = 1'b0, inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, outValid, outIsToken, parseErr;
  logic [7:0] outData;

  always #4 clk = ~clk;

  skelTokenMatcher #(.ENTRIES(ENTRIES), .FIFO_DEPTH(DEPTH)) u_skelTokenMatcher (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldIndex(ldIndex),
    .ldPattern(ldPattern), .ldMask(ldMask), .ldToken(ldToken),
    .ldFollow(ldFollow), .ldFollowEn(ldFollowEn), .ldFree(ldFree),
    .ldDone(ldDone), .docStart(docStart), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outIsToken(outIsToken),
    .outData(outData), .parseErr(parseErr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int readyMode = 0;
  int cyc = 0;

  logic [31:0] tPat   [ENTRIES];
  logic [3:0]  tMask  [ENTRIES];
  logic [7:0]  tTok   [ENTRIES];
  logic [7:0]  tFol   [ENTRIES];
  bit          tFolEn [ENTRIES];
  bit          tFree  [ENTRIES];

  logic [8:0] gotQ [$];
  logic [8:0] expQ [$];
  bit expErr;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      outReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? (cyc % 3 != 0) : 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (outValid && outReady) gotQ.push_back({outIsToken, outData});
    end
  end

  function automatic logic [31:0] pack4(input string s, input int base);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = s[base + k];
    return w;
  endfunction

  function automatic int lenOf(input logic [3:0] m);
    int n = 0;
    for (int k = 0; k < 4; k++) if (m[k]) n = k + 1;
    return n;
  endfunction

  function automatic void model(input string s);
    int pos = 0;
    int n = s.len();
    bit pend = 0;
    logic [7:0] pendId = '0;
    expQ.delete();
    expErr = 0;
    while (pos < n) begin
      int hitE = -1;
      for (int e = 0; e < ENTRIES; e++) begin
        if (hitE < 0 && tMask[e] != 0 && lenOf(tMask[e]) <= n - pos) begin
          bit ok = 1;
          for (int k = 0; k < lenOf(tMask[e]); k++)
            if (tMask[e][k] && s[pos + k] != tPat[e][8*k +: 8]) ok = 0;
          if (ok) hitE = e;
        end
      end
      if (hitE >= 0) begin
        expQ.push_back({1'b1, tTok[hitE]});
        if (!tFree[hitE]) begin
          if (pend && tTok[hitE] != pendId) expErr = 1;
          pend = tFolEn[hitE];
          pendId = tFol[hitE];
        end
        pos += lenOf(tMask[hitE]);
      end else begin
        expQ.push_back({1'b0, s[pos]});
        if (pend) expErr = 1;
        pend = 0;
        pos += 1;
      end
    end
  endfunction

  task automatic loadEntry(input int idx, input string p, input logic [3:0] m,
                           input logic [7:0] tok, input logic [7:0] fol,
                           input bit fen, input bit fr);
    @(negedge clk);
    ldValid = 1; ldIndex = IDX_W'(idx); ldPattern = pack4(p, 0); ldMask = m;
    ldToken = tok; ldFollow = fol; ldFollowEn = fen; ldFree = fr;
    tPat[idx] = pack4(p, 0); tMask[idx] = m; tTok[idx] = tok;
    tFol[idx] = fol; tFolEn[idx] = fen; tFree[idx] = fr;
    @(negedge clk);
    ldValid = 0;
  endtask

  task automatic sendWord(input logic [31:0] w, input bit last);
    bit acc;
    @(negedge clk);
    inValid = 1; inData = w; inLast = last;
    do begin
      #3;
      acc = inReady;
      @(negedge clk);
    end while (!acc);
    inValid = 0; inLast = 0;
  endtask

  task automatic feed(input string s, input bit last);
    int words = s.len() / 4;
    for (int w = 0; w < words; w++) sendWord(pack4(s, 4*w), last && (w == words - 1));
  endtask

  task automatic docBegin();
    @(negedge clk);
    docStart = 1;
    @(negedge clk);
    docStart = 0;
    gotQ.delete();
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compareItems(input string req);
    int m;
    check(gotQ.size() == expQ.size(), req, "item count", gotQ.size(), expQ.size());
    m = (gotQ.size() < expQ.size()) ? gotQ.size() : expQ.size();
    for (int i = 0; i < m; i++)
      check(gotQ[i] == expQ[i], req, $sformatf("item %0d", i), gotQ[i], expQ[i]);
  endtask

  task automatic runDoc(input string s, input string req);
    docBegin();
    feed(s, 1);
    settle(40);
    model(s);
    compareItems(req);
    #3;
    check(parseErr == expErr, req, "parseErr", parseErr, expErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string sw;
    string alpha;
    logic [7:0] held;
    for (int e = 0; e < ENTRIES; e++) begin
      tPat[e] = '0; tMask[e] = '0; tTok[e] = '0; tFol[e] = '0; tFolEn[e] = 0; tFree[e] = 0;
    end
    readyMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #3;
    // R1: quiet after reset
    check(inReady == 0, "R1", "inReady", inReady, 0);
    check(outValid == 0, "R1", "outValid", outValid, 0);
    check(parseErr == 0, "R1", "parseErr", parseErr, 0);

    loadEntry(0, "</st", 4'hF, 8'd14, 8'd15, 1, 0);
    #3;
    // R2: disarmed while loading
    check(inReady == 0, "R2", "inReady while loading", inReady, 0);
    loadEntry(1, "atus", 4'hF, 8'd15, 8'd0, 0, 0);
    loadEntry(2, "</pr", 4'hF, 8'd19, 8'd0, 0, 0);
    loadEntry(3, ">   ", 4'hF, 8'd16, 8'd0, 0, 1);
    loadEntry(4, ">  z", 4'h7, 8'd16, 8'd0, 0, 1);
    loadEntry(5, "> zz", 4'h3, 8'd16, 8'd0, 0, 1);
    loadEntry(6, "<zxz", 4'h5, 8'd20, 8'd0, 0, 0);
    loadEntry(7, "open", 4'hF, 8'd21, 8'd0, 0, 0);
    loadEntry(8, "<zzz", 4'h1, 8'd22, 8'd0, 0, 0);
    loadEntry(9, "</st", 4'hF, 8'd30, 8'd0, 0, 0);
    loadEntry(10, "abcd", 4'h0, 8'd31, 8'd0, 0, 0);
    @(negedge clk);
    ldDone = 1;
    @(negedge clk);
    ldDone = 0;
    #3;
    check(inReady == 1, "R2", "inReady after arm", inReady, 1);

    // R4 R5: tokens and raw bytes in a clean document
    runDoc("</status>   </presence> ", "R4");
    // R6 R8 R12: lowest index wins, 14 then 19 is an error, mask-zero entry never hits
    runDoc("</st</prabcd", "R6");
    // R10: error latched without docStart
    feed("open", 1);
    settle(10);
    #3;
    check(parseErr == 1, "R10", "parseErr latched", parseErr, 1);
    docBegin();
    #3;
    check(parseErr == 0, "R10", "parseErr after docStart", parseErr, 0);
    // R9: free token keeps the demand pending
    runDoc("</st>  </pre", "R9");
    runDoc("</st>  atusx", "R9");
    // R8: raw byte after a demanding token
    runDoc("</stzzzz", "R8");

    // R7: waits for four bytes, then matches the tail
    docBegin();
    feed("<ab<", 0);
    settle(10);
    #3;
    check(gotQ.size() == 1, "R7", "items before tail", gotQ.size(), 1);
    check(outValid == 0, "R7", "outValid with three bytes", outValid, 0);
    feed("?x  ", 1);
    settle(20);
    model("<ab<?x  ");
    compareItems("R7");

    // R3 R11: back-pressure fills the lanes and holds the output
    readyMode = 2;
    docBegin();
    feed("openopenopenopen", 1);
    settle(2);
    #3;
    check(inReady == 0, "R3", "inReady when full", inReady, 0);
    check(outValid == 1, "R11", "outValid held", outValid, 1);
    held = outData;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #3;
      check(outValid == 1 && outData == held, "R11", "held item", outData, held);
    end
    readyMode = 0;
    settle(20);
    model("openopenopenopen");
    compareItems("R11");

    // sweeps over swept character streams with a throttled consumer
    readyMode = 1;
    alpha = "</st>atus pren";
    for (int pass = 0; pass < 3; pass++) begin
      sw = "";
      for (int i = 0; i < 64; i++) begin
        int ix;
        ix = (pass == 0) ? (i*5 + i/3) : (pass == 1) ? (i*i + 3*i) : (i*11 + pass);
        sw = {sw, string'(alpha[ix % alpha.len()])};
      end
      runDoc(sw, "R4");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule